// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Direct Routing

This block gathers peripheral event lines into numbered groups of 32 sources each, groups 8 through 26 by default. Every group keeps a sticky source register that captures events, an enable register driven through separate write-1-set and write-1-clear locations, and a read-only result equal to source AND enable. Each group's result bits are ORed into one aggregated request line. That line reaches the downstream interrupt controller only while the group's bit in a block-enable mask is set.

A subset of groups may also drive one interrupt line per source. These direct lines follow the result bits, but only while a single global direct-mode bit is set. One group is reserved for wakeup. Its enabled, pending sources raise a wake request to clock and power logic, and the group drives no interrupt line of either kind. All state is read and written through a simple synchronous word-addressed register port with a combinational read path.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all sources, enables, the block-enable mask and the direct-mode bit are zero, so every output is low.
- R2: Group g (index i = g-8) has its enable write-1-set register at word address 4*i+1 and its write-1-clear register at 4*i+2. Writing 1 to a bit sets or clears that enable bit, writing 0 leaves it unchanged, and a read of either address returns the enable register.
- R3: Source bit b of group g latches when event input (i*32+b) is high at a clock edge. The bit is cleared by writing 1 to it at word 4*i+0, which also reads the source register. An event on the same edge as the clear leaves the bit set.
- R4: Word 4*i+3 reads the result, source AND enable. Writes to it have no effect.
- R5: The block-enable mask has a write-1-set register at word 0x80, which also reads the mask, and a write-1-clear register at 0x81, which reads 0. Bit n belongs to group n, and bits outside groups 8..26 always read 0.
- R6: Aggregated output bit i is high exactly when group 8+i has a nonzero result and mask bit 8+i is set. The bit for group 22 is always low.
- R7: Direct output bit i*32+b equals result bit b of group 8+i while the direct-mode bit is set and the group is one of 13..21 or 23. Otherwise it is low.
- R8: The direct-mode bit is bit 0 of the read/write word at 0x82. The other bits read 0.
- R9: The wake request is high exactly when group 22 has a nonzero result.
- R10: A read of any word not named above returns 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_GRP*32 | Peripheral event lines, group index major |
| reg_addr_i | input | ADDR_W | Word address of the register access |
| reg_wr_i | input | 1 | Write strobe for the current address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address (combinational) |
| grp_irq_o | output | NUM_GRP | Aggregated request per group |
| direct_irq_o | output | NUM_GRP*32 | Per-source direct requests |
| wake_req_o | output | 1 | Wake request to clock/power control |

## Verification
The bench builds the block with its default parameters: groups 8 to 26, 32 sources each, and the fixed direct-capable and wake-group choices. Under these values every group kind is reachable, including aggregated-only, direct-capable and wake-only groups, as well as the unmapped mask bits above group 26 and the unused addresses between the group window and the global words. Directed cases drive events that coincide with a clear, set the mask bit of the wake group, and turn on direct mode with aggregated-only groups pending. Random traffic then mixes sparse events with random writes across the whole address space.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants for the grouped interrupt aggregator.
// Assumes group numbers stay below 32 so one 32-bit mask covers them.
package irq_agg_pkg;
    localparam int SRC_W     = 32;             // sources per group
    localparam int MASK_W    = 32;             // width of group-number masks
    localparam int ADDR_W    = 8;              // register word address width
    localparam int REGS_PER  = 4;              // words per group
    localparam logic [1:0] K_SRC = 2'd0;       // source, write-1-clear
    localparam logic [1:0] K_SET = 2'd1;       // enable write-1-set
    localparam logic [1:0] K_CLR = 2'd2;       // enable write-1-clear
    localparam logic [1:0] K_RES = 2'd3;       // result, read only
    localparam logic [ADDR_W-1:0] A_BLK_SET = 8'h80;
    localparam logic [ADDR_W-1:0] A_BLK_CLR = 8'h81;
    localparam logic [ADDR_W-1:0] A_DIRMODE = 8'h82;
endpackage

// File: rtl/irq_src_slice.sv
// Module: one group's source and enable registers with its result.
// Assumes strobes arrive already decoded for this group; the same write
// data is shared by all groups.
module irq_src_slice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] wdata_i,
    input  logic         src_clr_i,
    input  logic         en_set_i,
    input  logic         en_clr_i,
    output logic [W-1:0] src_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] res_o
);
    logic [W-1:0] src_q;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_mask;

    // Purpose: clear mask applies only on a write to the source word.
    always_comb clr_mask = src_clr_i ? wdata_i : '0;

    // Purpose: sticky sources; a new event outranks a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_mask) | evt_i;
    end

    // Purpose: enable bits set or cleared by written ones.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (en_set_i) en_q <= en_q | wdata_i;
        else if (en_clr_i) en_q <= en_q & ~wdata_i;
    end

    // Purpose: masked result.
    always_comb res_o = src_q & en_q;

    assign src_o = src_q;
    assign en_o  = en_q;

    // R3: an event always leaves its bit set.
    p_evt_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));
    // R2: without a strobe the enable holds.
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set_i && !en_clr_i) |=> $stable(en_q));
    // R3: without a clear no source bit falls.
    p_src_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_clr_i |=> ((src_q & $past(src_q)) == $past(src_q)));
endmodule

// File: rtl/irq_regfile.sv
// Module: address decode, global registers and read multiplexer.
// Assumes the group window (NUM_GRP*4 words) lies below the global words.
module irq_regfile
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP   = 19,
    parameter int FIRST_GRP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_i,
    input  logic [SRC_W-1:0]         wdata_i,
    input  logic [NUM_GRP*SRC_W-1:0] src_all_i,
    input  logic [NUM_GRP*SRC_W-1:0] en_all_i,
    input  logic [NUM_GRP*SRC_W-1:0] res_all_i,
    output logic [NUM_GRP-1:0]       src_clr_o,
    output logic [NUM_GRP-1:0]       en_set_o,
    output logic [NUM_GRP-1:0]       en_clr_o,
    output logic [MASK_W-1:0]        blk_en_o,
    output logic                     dir_mode_o,
    output logic [SRC_W-1:0]         rdata_o
);
    localparam int GRP_SPAN = NUM_GRP * REGS_PER;
    localparam logic [MASK_W-1:0] GRP_VALID =
        ((MASK_W'(1) << NUM_GRP) - MASK_W'(1)) << FIRST_GRP;

    logic              in_grp;
    int                gidx;
    logic [1:0]        kind;
    logic [MASK_W-1:0] blk_q;
    logic              dir_q;
    logic              wr_blk_set, wr_blk_clr, wr_dir;

    // Purpose: split the word address into group index and register kind.
    always_comb begin
        in_grp = (int'(addr_i) < GRP_SPAN);
        gidx   = int'(addr_i) / REGS_PER;
        kind   = addr_i[1:0];
    end

    // Purpose: per-group write strobes.
    always_comb begin
        src_clr_o = '0;
        en_set_o  = '0;
        en_clr_o  = '0;
        if (wr_i && in_grp) begin
            for (int i = 0; i < NUM_GRP; i++) begin
                if (gidx == i) begin
                    src_clr_o[i] = (kind == K_SRC);
                    en_set_o[i]  = (kind == K_SET);
                    en_clr_o[i]  = (kind == K_CLR);
                end
            end
        end
    end

    // Purpose: global write strobes.
    always_comb begin
        wr_blk_set = wr_i && (addr_i == A_BLK_SET);
        wr_blk_clr = wr_i && (addr_i == A_BLK_CLR);
        wr_dir     = wr_i && (addr_i == A_DIRMODE);
    end

    // Purpose: block-enable mask, restricted to existing groups.
    always_ff @(posedge clk) begin
        if (!rst_n)          blk_q <= '0;
        else if (wr_blk_set) blk_q <= blk_q | (wdata_i & GRP_VALID);
        else if (wr_blk_clr) blk_q <= blk_q & ~wdata_i;
    end

    // Purpose: global direct-mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (wr_dir) dir_q <= wdata_i[0];
    end

    // Purpose: read multiplexer; unmapped words read zero.
    always_comb begin
        rdata_o = '0;
        if (in_grp) begin
            for (int i = 0; i < NUM_GRP; i++) begin
                if (gidx == i) begin
                    unique case (kind)
                        K_SRC:        rdata_o = src_all_i[i*SRC_W +: SRC_W];
                        K_SET, K_CLR: rdata_o = en_all_i[i*SRC_W +: SRC_W];
                        K_RES:        rdata_o = res_all_i[i*SRC_W +: SRC_W];
                        default:      rdata_o = '0;
                    endcase
                end
            end
        end else if (addr_i == A_BLK_SET) begin
            rdata_o = blk_q;
        end else if (addr_i == A_DIRMODE) begin
            rdata_o = {{(SRC_W-1){1'b0}}, dir_q};
        end
    end

    assign blk_en_o   = blk_q;
    assign dir_mode_o = dir_q;

    // R1: reset clears the global state.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (blk_q == '0 && !dir_q));
    // R5: written ones show up in the mask for existing groups.
    p_blk_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blk_set |=> ((blk_q & $past(wdata_i & GRP_VALID)) == $past(wdata_i & GRP_VALID)));
    // R5: written ones leave the mask on a clear.
    p_blk_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blk_clr |=> ((blk_q & $past(wdata_i)) == '0));
    // R8: direct-mode bit follows bit 0 of its write.
    p_dir_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wdata_i[0])));
endmodule

// File: rtl/irq_router.sv
// Module: aggregated, direct and wake outputs from the group results.
// Assumes one capability mask and one wake group number, both absolute.
module irq_router
    import irq_agg_pkg::*;
#(
    parameter int                NUM_GRP    = 19,
    parameter int                FIRST_GRP  = 8,
    parameter int                WAKE_GRP   = 22,
    parameter logic [MASK_W-1:0] DIRECT_CAP = 32'h00BF_E000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*SRC_W-1:0] res_all_i,
    input  logic [MASK_W-1:0]        blk_en_i,
    input  logic                     dir_mode_i,
    output logic [NUM_GRP-1:0]       grp_irq_o,
    output logic [NUM_GRP*SRC_W-1:0] direct_o,
    output logic                     wake_o
);
    logic [NUM_GRP-1:0] any_res;

    for (genvar i = 0; i < NUM_GRP; i++) begin : g_grp
        localparam int GNUM = FIRST_GRP + i;
        // Purpose: any pending, enabled source in the group.
        always_comb any_res[i] = |res_all_i[i*SRC_W +: SRC_W];

        if (GNUM == WAKE_GRP) begin : g_wake
            // Purpose: wake group feeds only the wake request.
            always_comb grp_irq_o[i] = 1'b0;
            always_comb direct_o[i*SRC_W +: SRC_W] = '0;
        end else begin : g_norm
            // Purpose: aggregated line gated by the block-enable mask.
            always_comb grp_irq_o[i] = any_res[i] & blk_en_i[GNUM];
            if (DIRECT_CAP[GNUM]) begin : g_dir
                // Purpose: per-source lines gated by direct mode.
                always_comb direct_o[i*SRC_W +: SRC_W] =
                    res_all_i[i*SRC_W +: SRC_W] & {SRC_W{dir_mode_i}};
            end else begin : g_nodir
                always_comb direct_o[i*SRC_W +: SRC_W] = '0;
            end
        end

        // R6: an aggregated line needs its mask bit and a pending result.
        p_agg_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq_o[i] |-> (blk_en_i[GNUM] && any_res[i]));
    end

    // Purpose: wake request from the wake group's result.
    if (WAKE_GRP >= FIRST_GRP && WAKE_GRP < FIRST_GRP + NUM_GRP) begin : g_wk
        always_comb wake_o = any_res[WAKE_GRP - FIRST_GRP];
    end else begin : g_nowk
        always_comb wake_o = 1'b0;
    end

    // R7: no direct line while direct mode is off.
    p_no_direct_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_mode_i |-> (direct_o == '0));
    // R7: direct lines never exceed the results.
    p_direct_in_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((direct_o & ~res_all_i) == '0));
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the grouped interrupt aggregator. Instantiates one slice
// per group, the register file and the output router.
// Assumes a synchronous active-low reset and single-cycle register writes.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int                NUM_GRP    = 19,
    parameter int                FIRST_GRP  = 8,
    parameter int                WAKE_GRP   = 22,
    parameter logic [MASK_W-1:0] DIRECT_CAP = 32'h00BF_E000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*SRC_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic                     reg_wr_i,
    input  logic [SRC_W-1:0]         reg_wdata_i,
    output logic [SRC_W-1:0]         reg_rdata_o,
    output logic [NUM_GRP-1:0]       grp_irq_o,
    output logic [NUM_GRP*SRC_W-1:0] direct_irq_o,
    output logic                     wake_req_o
);
    logic [NUM_GRP*SRC_W-1:0] src_all, en_all, res_all;
    logic [NUM_GRP-1:0]       src_clr, en_set, en_clr;
    logic [MASK_W-1:0]        blk_en;
    logic                     dir_mode;

    for (genvar i = 0; i < NUM_GRP; i++) begin : g_slice
        irq_src_slice #(.W(SRC_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[i*SRC_W +: SRC_W]),
            .wdata_i   (reg_wdata_i),
            .src_clr_i (src_clr[i]),
            .en_set_i  (en_set[i]),
            .en_clr_i  (en_clr[i]),
            .src_o     (src_all[i*SRC_W +: SRC_W]),
            .en_o      (en_all[i*SRC_W +: SRC_W]),
            .res_o     (res_all[i*SRC_W +: SRC_W])
        );
    end

    irq_regfile #(.NUM_GRP(NUM_GRP), .FIRST_GRP(FIRST_GRP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .src_all_i  (src_all),
        .en_all_i   (en_all),
        .res_all_i  (res_all),
        .src_clr_o  (src_clr),
        .en_set_o   (en_set),
        .en_clr_o   (en_clr),
        .blk_en_o   (blk_en),
        .dir_mode_o (dir_mode),
        .rdata_o    (reg_rdata_o)
    );

    irq_router #(
        .NUM_GRP(NUM_GRP), .FIRST_GRP(FIRST_GRP),
        .WAKE_GRP(WAKE_GRP), .DIRECT_CAP(DIRECT_CAP)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_all_i  (res_all),
        .blk_en_i   (blk_en),
        .dir_mode_i (dir_mode),
        .grp_irq_o  (grp_irq_o),
        .direct_o   (direct_irq_o),
        .wake_o     (wake_req_o)
    );

    // R9: wake request implies the wake group has pending, enabled sources.
    p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (|res_all[(WAKE_GRP-FIRST_GRP)*SRC_W +: SRC_W]));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 19;
    localparam int FG = 8;
    localparam int W  = 32;
    localparam int NB = NG * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] evt = '0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NG-1:0] grp_irq;
    logic [NB-1:0] dir_irq;
    logic          wake;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [31:0] m_src [NG];
    logic [31:0] m_en  [NG];
    logic [31:0] m_blk;
    logic        m_dir;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .grp_irq_o(grp_irq), .direct_irq_o(dir_irq), .wake_req_o(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit can_direct(int g);
        return (g >= 13 && g <= 21) || g == 23;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int i;
        i = int'(a) / 4;
        if (int'(a) < NG*4) begin
            case (a[1:0])
                2'd0: return m_src[i];
                2'd1, 2'd2: return m_en[i];
                default: return m_src[i] & m_en[i];
            endcase
        end
        if (a == 8'h80) return m_blk;
        if (a == 8'h82) return {31'd0, m_dir};
        return 32'd0;
    endfunction

    function automatic logic [NG-1:0] exp_grp();
        logic [NG-1:0] v;
        for (int i = 0; i < NG; i++)
            v[i] = (FG+i != 22) && m_blk[FG+i] && |(m_src[i] & m_en[i]);
        return v;
    endfunction

    function automatic logic [NB-1:0] exp_dir();
        logic [NB-1:0] v;
        for (int i = 0; i < NG; i++)
            v[i*W +: W] = (m_dir && can_direct(FG+i)) ? (m_src[i] & m_en[i]) : 32'd0;
        return v;
    endfunction

    function automatic logic exp_wake();
        return |(m_src[22-FG] & m_en[22-FG]);
    endfunction

    task automatic chk(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NG; i++) begin m_src[i] = '0; m_en[i] = '0; end
        m_blk = '0;
        m_dir = 1'b0;
    endtask

    // Update the model with the values present at the clock edge.
    task automatic model_edge();
        int i;
        i = int'(addr) / 4;
        for (int g = 0; g < NG; g++) begin
            logic [31:0] clr;
            clr = (wr && int'(addr) < NG*4 && i == g && addr[1:0] == 2'd0) ? wdata : 32'd0;
            m_src[g] = (m_src[g] & ~clr) | evt[g*W +: W];
        end
        if (wr && int'(addr) < NG*4) begin
            if (addr[1:0] == 2'd1) m_en[i] = m_en[i] | wdata;
            if (addr[1:0] == 2'd2) m_en[i] = m_en[i] & ~wdata;
        end
        if (wr && addr == 8'h80) m_blk = m_blk | (wdata & 32'h07FF_FF00);
        if (wr && addr == 8'h81) m_blk = m_blk & ~wdata;
        if (wr && addr == 8'h82) m_dir = wdata[0];
    endtask

    task automatic check_outs(string req);
        chk({req, " aggregated"}, NB'(grp_irq), NB'(exp_grp()));
        chk({req, " direct"}, dir_irq, exp_dir());
        chk({req, " wake"}, NB'(wake), NB'(exp_wake()));
    endtask

    // One cycle: drive at the falling edge, check read data, take the edge.
    task automatic cycle(string req, logic [NB-1:0] e, logic [7:0] a, logic w, logic [31:0] d);
        @(negedge clk);
        evt = e; addr = a; wr = w; wdata = d;
        #1;
        chk({req, " read"}, NB'(rdata), NB'(exp_read(a)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        evt = '0; wr = 1'b0;
        check_outs(req);
    endtask

    function automatic logic [NB-1:0] one_evt(int g, int b);
        logic [NB-1:0] v;
        v = '0;
        v[(g-FG)*W + b] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] ga(int g, int k);
        return 8'((g-FG)*4 + k);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD*150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [NB-1:0] e;
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        check_outs("R1");
        cycle("R1", '0, 8'h80, 1'b0, '0);
        cycle("R1", '0, ga(15, 0), 1'b0, '0);

        // R2: set, write-zero no effect, clear.
        cycle("R2", '0, ga(13, 1), 1'b1, 32'h0000_00F0);
        cycle("R2", '0, ga(13, 1), 1'b1, 32'h0);
        cycle("R2", '0, ga(13, 2), 1'b1, 32'h0);
        cycle("R2", '0, ga(13, 2), 1'b1, 32'h0000_0030);
        cycle("R2", '0, ga(13, 2), 1'b0, 32'h0);

        // R3: latch, clear, event on the clear edge wins.
        cycle("R3", one_evt(13, 4), ga(13, 0), 1'b0, '0);
        cycle("R3", '0, ga(13, 0), 1'b0, '0);
        cycle("R3", one_evt(13, 4), ga(13, 0), 1'b1, 32'h0000_0010);
        cycle("R3", '0, ga(13, 0), 1'b1, 32'h0000_0010);
        cycle("R3", '0, ga(13, 0), 1'b0, '0);

        // R4: result reads and ignores writes.
        cycle("R4", one_evt(13, 6), ga(13, 3), 1'b0, '0);
        cycle("R4", '0, ga(13, 3), 1'b1, 32'hFFFF_FFFF);
        cycle("R4", '0, ga(13, 3), 1'b0, '0);

        // R5/R6: mask write with unmapped bits; aggregated line follows.
        cycle("R5", '0, 8'h80, 1'b1, 32'hFFFF_FFFF);
        cycle("R5", '0, 8'h80, 1'b0, '0);
        cycle("R5", '0, 8'h81, 1'b0, '0);
        cycle("R6", '0, 8'h81, 1'b1, 32'h0000_2000);
        cycle("R6", '0, 8'h80, 1'b1, 32'h0000_2000);

        // R6/R9: wake group with its mask bit set raises only wake.
        cycle("R9", '0, ga(22, 1), 1'b1, 32'h1);
        cycle("R9", one_evt(22, 0), ga(22, 0), 1'b0, '0);
        cycle("R6", '0, ga(22, 3), 1'b0, '0);
        cycle("R9", '0, ga(22, 0), 1'b1, 32'h1);

        // R7: aggregated-only group pending, direct off then on.
        cycle("R7", one_evt(9, 2), ga(9, 1), 1'b1, 32'h4);
        cycle("R7", '0, ga(9, 3), 1'b0, '0);
        cycle("R8", '0, 8'h82, 1'b1, 32'hFFFF_FFFF);
        cycle("R8", '0, 8'h82, 1'b0, '0);
        cycle("R7", one_evt(23, 31), ga(23, 1), 1'b1, 32'h8000_0000);
        cycle("R7", '0, ga(23, 3), 1'b0, '0);
        cycle("R8", '0, 8'h82, 1'b1, 32'h2);
        cycle("R7", '0, ga(23, 3), 1'b0, '0);

        // R10: unmapped words read zero and writes change nothing.
        cycle("R10", '0, 8'h4C, 1'b1, 32'hFFFF_FFFF);
        cycle("R10", '0, 8'h7F, 1'b1, 32'hFFFF_FFFF);
        cycle("R10", '0, 8'h83, 1'b1, 32'hFFFF_FFFF);
        cycle("R10", '0, 8'hFF, 1'b0, '0);

        // Random traffic across all requirements.
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int r;
            for (int k = 0; k < NG; k++)
                e[k*W +: W] = $urandom() & $urandom() & $urandom() & $urandom();
            if (($urandom() % 4) != 0) e = '0;
            r = int'($urandom() % 10);
            if (r < 7)       a = 8'($urandom() % (NG*4));
            else if (r < 9)  a = 8'h80 + 8'($urandom() % 3);
            else             a = 8'($urandom());
            d = (($urandom() % 5) == 0) ? 32'hFFFF_FFFF : $urandom();
            cycle("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", e, a, ($urandom() % 2) == 1, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule